// File: doc/BRIEF.md
# Accumulating Multiplier with Rounding and Clamping

This block multiplies two signed operands on every cycle that carries a valid input and adds the product into a 44-bit running sum. A clear input restarts the sum from the current product. The sum then passes through a post-processing stage that can round it at a fixed bit position and clamp it at another fixed bit position. Each of these two operations has its own per-cycle enable, which travels with the input.

The rounding position is a parameter and must lie between bit 6 and bit 21. The clamping position is a parameter and must lie between bit 28 and bit 43. Neither can change at run time, and a value outside its window stops elaboration. A third parameter selects symmetric clamping. In that mode the negative limit mirrors the positive one, and both limits have every bit below the rounding position cleared. When both operations are enabled, rounding always comes first, so a carry out of rounding can push a value into the clamp.

One register sits after the accumulator. The processed result, its valid strobe and a clamp indicator therefore appear two cycles after the input that completed the sum.

Top module: `acc_rndsat`

## Requirements
- R1: After reset, out_valid, sat_flag and result are all zero, and the accumulator holds zero, so the first accumulation without a clear yields the product alone.
- R2: On a cycle with in_valid high and acc_clr low, the accumulator adds the sign-extended signed product op_a×op_b. A cycle with both in_valid and acc_clr low leaves the accumulator unchanged. The accumulator wraps modulo 2^44.
- R3: With acc_clr and in_valid high together, the accumulator loads the current product. With acc_clr high and in_valid low, it loads zero.
- R4: out_valid is high exactly two cycles after in_valid. result and sat_flag then describe the sum that includes that cycle's product, processed under the rnd_en and sat_en values sampled in that same cycle. While out_valid is low, result holds its last value and sat_flag is low.
- R5: With rounding enabled, the sum is increased by 2^(RND_POS-1), and bits below RND_POS are then cleared. Exact halves therefore round toward positive infinity.
- R6: With rounding disabled, the sum reaches the clamp stage unchanged.
- R7: With clamping enabled and SYMMETRIC=0, a value above 2^SAT_POS-1 becomes 2^SAT_POS-1 and a value below -2^SAT_POS becomes -2^SAT_POS, both sign-extended to 44 bits. sat_flag is high exactly when a value was replaced.
- R8: With clamping enabled and SYMMETRIC=1, the limits are +(2^SAT_POS-2^RND_POS) and -(2^SAT_POS-2^RND_POS). A clamped value has zero in every bit below RND_POS.
- R9: When both operations are enabled, clamping acts on the rounded value. Rounding is carried out one bit wider than the bus, so a carry out of rounding cannot wrap before it reaches the clamp.
- R10: With clamping disabled, result is the low 44 bits of the value from the round stage, and sat_flag stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acc_clr | input | 1 | Restart the sum from this cycle's product, or from zero if no valid input |
| in_valid | input | 1 | Operands are valid this cycle |
| op_a | input | A_W | Signed multiplicand |
| op_b | input | B_W | Signed multiplier |
| rnd_en | input | 1 | Apply rounding to the sum this input completes |
| sat_en | input | 1 | Apply clamping to the sum this input completes |
| result | output | 44 | Processed sum, two's complement |
| out_valid | output | 1 | result is new this cycle |
| sat_flag | output | 1 | result was clamped this cycle |

## Verification
The assertions assume that every control input is a known 0 or 1 after reset. They also assume that the parameters lie within their legal windows, so that the limit constants used by the checks are meaningful. The stimulus drives every input to a defined value from time zero onward and changes inputs only between clock edges. A second instance built with symmetric clamping receives the same input sequence as the first. Random operands are biased toward the extreme 18-bit values, and clears are kept rare, so that long runs of accumulation reach both limits and wrap the 44-bit sum.

// File: rtl/acc_rndsat_pkg.sv
package acc_rndsat_pkg;

    localparam int BUS_W  = 44;
    localparam int EXT_W  = BUS_W + 1;
    localparam int RND_LO = 6;
    localparam int RND_HI = 21;
    localparam int SAT_LO = 28;
    localparam int SAT_HI = 43;

    typedef logic signed [BUS_W-1:0] bus_t;
    typedef logic signed [EXT_W-1:0] ext_t;

    typedef struct packed {
        logic valid;
        logic rnd_en;
        logic sat_en;
    } ctl_t;

    function automatic ext_t round_offset(int pos);
        ext_t one = ext_t'(1);
        return one <<< (pos - 1);
    endfunction

    function automatic ext_t keep_mask(int pos);
        ext_t one = ext_t'(1);
        return ~((one <<< pos) - one);
    endfunction

    function automatic ext_t pos_limit(int sat_pos, int rnd_pos, bit sym);
        ext_t one = ext_t'(1);
        return sym ? ((one <<< sat_pos) - (one <<< rnd_pos)) : ((one <<< sat_pos) - one);
    endfunction

    function automatic ext_t neg_limit(int sat_pos, int rnd_pos, bit sym);
        ext_t one = ext_t'(1);
        return sym ? -pos_limit(sat_pos, rnd_pos, sym) : -(one <<< sat_pos);
    endfunction

endpackage

// File: rtl/acc_stage.sv
module acc_stage
    import acc_rndsat_pkg::*;
#(
    parameter int A_W = 18,
    parameter int B_W = 18
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  acc_clr,
    input  logic                  in_valid,
    input  logic signed [A_W-1:0] op_a,
    input  logic signed [B_W-1:0] op_b,
    input  logic                  rnd_en,
    input  logic                  sat_en,
    output bus_t                  acc_q,
    output ctl_t                  ctl_q
);
    localparam int P_W = A_W + B_W;

    logic signed [P_W-1:0] prod;
    bus_t                  prod_x;

    assign prod   = op_a * op_b;
    assign prod_x = {{(BUS_W-P_W){prod[P_W-1]}}, prod};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            ctl_q <= '0;
        end else begin
            if (in_valid) begin
                acc_q <= acc_clr ? prod_x : acc_q + prod_x;
            end else if (acc_clr) begin
                acc_q <= '0;
            end
            ctl_q <= '{valid: in_valid, rnd_en: rnd_en, sat_en: sat_en};
        end
    end

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !acc_clr) |=> $stable(acc_q));

    a_r3_clear_idle: assert property (@(posedge clk) disable iff (rst)
        (acc_clr && !in_valid) |=> (acc_q == '0));

    a_r4_valid_stage1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ctl_q.valid);

endmodule

// File: rtl/rnd_unit.sv
module rnd_unit
    import acc_rndsat_pkg::*;
#(
    parameter int RND_POS = 10
) (
    input  bus_t din,
    input  logic rnd_en,
    output ext_t dout
);
    localparam ext_t OFFSET = round_offset(RND_POS);
    localparam ext_t MASK   = keep_mask(RND_POS);

    ext_t din_x;

    assign din_x = ext_t'(din);

    always_comb begin
        if (rnd_en) dout = (din_x + OFFSET) & MASK;
        else        dout = din_x;
    end
endmodule

// File: rtl/sat_unit.sv
module sat_unit
    import acc_rndsat_pkg::*;
#(
    parameter int RND_POS   = 10,
    parameter int SAT_POS   = 36,
    parameter bit SYMMETRIC = 1'b0
) (
    input  ext_t                din,
    input  logic                sat_en,
    output logic [BUS_W-1:0]    dout,
    output logic                clamped
);
    localparam ext_t HI_LIM = pos_limit(SAT_POS, RND_POS, SYMMETRIC);
    localparam ext_t LO_LIM = neg_limit(SAT_POS, RND_POS, SYMMETRIC);

    always_comb begin
        dout    = din[BUS_W-1:0];
        clamped = 1'b0;
        if (sat_en) begin
            if (din > HI_LIM) begin
                dout    = HI_LIM[BUS_W-1:0];
                clamped = 1'b1;
            end else if (din < LO_LIM) begin
                dout    = LO_LIM[BUS_W-1:0];
                clamped = 1'b1;
            end
        end
    end
endmodule

// File: rtl/acc_rndsat.sv
module acc_rndsat
    import acc_rndsat_pkg::*;
#(
    parameter int A_W       = 18,
    parameter int B_W       = 18,
    parameter int RND_POS   = 10,
    parameter int SAT_POS   = 36,
    parameter bit SYMMETRIC = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  acc_clr,
    input  logic                  in_valid,
    input  logic signed [A_W-1:0] op_a,
    input  logic signed [B_W-1:0] op_b,
    input  logic                  rnd_en,
    input  logic                  sat_en,
    output logic [BUS_W-1:0]      result,
    output logic                  out_valid,
    output logic                  sat_flag
);
    localparam ext_t HI_LIM = pos_limit(SAT_POS, RND_POS, SYMMETRIC);
    localparam ext_t LO_LIM = neg_limit(SAT_POS, RND_POS, SYMMETRIC);

    if (RND_POS < RND_LO || RND_POS > RND_HI) begin : g_bad_rnd
        $error("rounding position outside legal window");
    end
    if (SAT_POS < SAT_LO || SAT_POS > SAT_HI) begin : g_bad_sat
        $error("clamp position outside legal window");
    end
    if (A_W + B_W > BUS_W) begin : g_bad_width
        $error("product wider than accumulator");
    end

    bus_t              acc_q;
    ctl_t              ctl_q;
    ext_t              rnd_out;
    logic [BUS_W-1:0]  sat_out;
    logic              clamped;
    logic              rnd_q2;
    logic              sat_q2;
    ext_t              res_x;

    acc_stage #(.A_W(A_W), .B_W(B_W)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .acc_clr  (acc_clr),
        .in_valid (in_valid),
        .op_a     (op_a),
        .op_b     (op_b),
        .rnd_en   (rnd_en),
        .sat_en   (sat_en),
        .acc_q    (acc_q),
        .ctl_q    (ctl_q)
    );

    rnd_unit #(.RND_POS(RND_POS)) u_rnd (
        .din    (acc_q),
        .rnd_en (ctl_q.rnd_en),
        .dout   (rnd_out)
    );

    sat_unit #(.RND_POS(RND_POS), .SAT_POS(SAT_POS), .SYMMETRIC(SYMMETRIC)) u_sat (
        .din     (rnd_out),
        .sat_en  (ctl_q.sat_en),
        .dout    (sat_out),
        .clamped (clamped)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result    <= '0;
            out_valid <= 1'b0;
            sat_flag  <= 1'b0;
            rnd_q2    <= 1'b0;
            sat_q2    <= 1'b0;
        end else begin
            out_valid <= ctl_q.valid;
            sat_flag  <= ctl_q.valid & clamped;
            if (ctl_q.valid) begin
                result <= sat_out;
                rnd_q2 <= ctl_q.rnd_en;
                sat_q2 <= ctl_q.sat_en;
            end
        end
    end

    assign res_x = ext_t'($signed(result));

    a_r4_valid_stage2: assert property (@(posedge clk) disable iff (rst)
        ctl_q.valid |=> out_valid);

    a_r4_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !ctl_q.valid |=> (!out_valid && !sat_flag && $stable(result)));

    a_r5_round_low_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && rnd_q2 && !sat_flag) |-> (result[RND_POS-1:0] == '0));

    a_r7_within_limits: assert property (@(posedge clk) disable iff (rst)
        (out_valid && sat_q2) |-> (res_x <= HI_LIM && res_x >= LO_LIM));

    a_r7_flag_at_limit: assert property (@(posedge clk) disable iff (rst)
        sat_flag |-> (res_x == HI_LIM || res_x == LO_LIM));

    a_r10_no_flag_when_off: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !sat_q2) |-> !sat_flag);

    if (SYMMETRIC) begin : g_sym_chk
        a_r8_sym_low_zero: assert property (@(posedge clk) disable iff (rst)
            sat_flag |-> (result[RND_POS-1:0] == '0));
    end

endmodule

// File: tb/test_acc_rndsat.sv
module test_acc_rndsat;
    localparam int AW = 18;
    localparam int BW = 18;
    localparam int RP = 10;
    localparam int SP = 36;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acc_clr = 1'b0;
    logic in_valid = 1'b0;
    logic rnd_en = 1'b0;
    logic sat_en = 1'b0;
    logic signed [AW-1:0] op_a = '0;
    logic signed [BW-1:0] op_b = '0;

    logic [43:0] res_a, res_s;
    logic        ov_a, ov_s, sf_a, sf_s;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    string req_a = "R1";
    string req_s = "R1";

    longint acc_m;
    bit     v1_m, r1_m, s1_m;
    bit     exp_ov;
    longint exp_res [2];
    bit     exp_sf  [2];

    always #10 clk = ~clk;

    acc_rndsat #(.A_W(AW), .B_W(BW), .RND_POS(RP), .SAT_POS(SP), .SYMMETRIC(1'b0)) i_acc_rndsat (
        .clk(clk), .rst(rst), .acc_clr(acc_clr), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .rnd_en(rnd_en), .sat_en(sat_en),
        .result(res_a), .out_valid(ov_a), .sat_flag(sf_a));

    acc_rndsat #(.A_W(AW), .B_W(BW), .RND_POS(RP), .SAT_POS(SP), .SYMMETRIC(1'b1)) i_acc_rndsat_sym (
        .clk(clk), .rst(rst), .acc_clr(acc_clr), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .rnd_en(rnd_en), .sat_en(sat_en),
        .result(res_s), .out_valid(ov_s), .sat_flag(sf_s));

    function automatic longint sx44(longint v);
        return (v <<< 20) >>> 20;
    endfunction

    function automatic longint proc_val(longint acc, bit r, bit s, bit sym, output bit clamp);
        longint one = 1;
        longint v = acc;
        longint hi, lo;
        clamp = 1'b0;
        if (r) v = (v + (one <<< (RP - 1))) & ~((one <<< RP) - one);
        if (s) begin
            hi = sym ? (one <<< SP) - (one <<< RP) : (one <<< SP) - one;
            lo = sym ? -hi : -(one <<< SP);
            if (v > hi) begin v = hi; clamp = 1'b1; end
            else if (v < lo) begin v = lo; clamp = 1'b1; end
        end
        return sx44(v);
    endfunction

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare_outputs();
        check(req_a, "asym out_valid", longint'(ov_a), longint'(exp_ov));
        check(req_s, "sym out_valid",  longint'(ov_s), longint'(exp_ov));
        check(req_a, "asym result", sx44(longint'($signed(res_a))), exp_res[0]);
        check(req_s, "sym result",  sx44(longint'($signed(res_s))), exp_res[1]);
        check(req_a, "asym sat_flag", longint'(sf_a), longint'(exp_sf[0]));
        check(req_s, "sym sat_flag",  longint'(sf_s), longint'(exp_sf[1]));
    endtask

    task automatic model_step();
        longint prod;
        bit c;
        exp_ov = v1_m;
        for (int i = 0; i < 2; i++) begin
            if (v1_m) begin
                exp_res[i] = proc_val(acc_m, r1_m, s1_m, bit'(i), c);
                exp_sf[i]  = c;
            end else begin
                exp_sf[i]  = 1'b0;
            end
        end
        prod = longint'(op_a) * longint'(op_b);
        if (in_valid) acc_m = acc_clr ? prod : sx44(acc_m + prod);
        else if (acc_clr) acc_m = 0;
        v1_m = in_valid;
        r1_m = rnd_en;
        s1_m = sat_en;
    endtask

    task automatic cyc(bit v, bit c, longint a, longint b, bit r, bit s);
        in_valid = v;
        acc_clr  = c;
        op_a     = AW'(a);
        op_b     = BW'(b);
        rnd_en   = r;
        sat_en   = s;
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_outputs();
    endtask

    task automatic flush();
        for (int k = 0; k < 3; k++) cyc(1'b0, 1'b0, 0, 0, 1'b0, 1'b0);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        acc_m = 0; v1_m = 0; r1_m = 0; s1_m = 0; exp_ov = 0;
        exp_res[0] = 0; exp_res[1] = 0; exp_sf[0] = 0; exp_sf[1] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state at the ports
        check("R1", "out_valid after reset", longint'(ov_a), 0);
        check("R1", "sat_flag after reset", longint'(sf_a), 0);
        check("R1", "result after reset", longint'(res_a), 0);

        // R1: accumulator starts from zero
        req_a = "R1"; req_s = "R1";
        cyc(1, 0, 3, 4, 0, 0);
        // R2: signed accumulation, then idle cycles hold
        req_a = "R2"; req_s = "R2";
        cyc(1, 0, -5, 6, 0, 0);
        req_a = "R4"; req_s = "R4";
        flush();
        req_a = "R2"; req_s = "R2";
        cyc(1, 0, 1, 1, 0, 0);
        flush();

        // R3: clear with and without valid
        req_a = "R3"; req_s = "R3";
        cyc(1, 1, 7, -3, 0, 0);
        cyc(0, 1, 9, 9, 0, 0);
        cyc(1, 0, 2, 2, 0, 0);
        flush();

        // R5: half-up rounding around the tie points
        req_a = "R5"; req_s = "R5";
        cyc(1, 1, 16, 32, 1, 0);
        cyc(1, 1, 511, 1, 1, 0);
        cyc(1, 1, -512, 1, 1, 0);
        cyc(1, 1, -513, 1, 1, 0);
        cyc(1, 1, 1535, 1, 1, 0);
        // R6: rounding off passes the sum
        req_a = "R6"; req_s = "R6";
        cyc(1, 1, 1535, 1, 0, 0);
        flush();

        // R7 / R8: positive clamp
        req_a = "R7"; req_s = "R8";
        cyc(1, 1, -131072, -131072, 0, 1);
        for (int k = 0; k < 4; k++) cyc(1, 0, -131072, -131072, 0, 1);
        // negative clamp, hitting exactly -2^36 on the way
        cyc(1, 1, -131072, 65536, 0, 1);
        for (int k = 0; k < 8; k++) cyc(1, 0, -131072, 65536, 0, 1);
        flush();

        // R9: rounding carry drives the value over the limit
        req_a = "R9"; req_s = "R9";
        cyc(1, 1, -131072, -131072, 0, 0);
        for (int k = 0; k < 3; k++) cyc(1, 0, -131072, -131072, 0, 0);
        cyc(1, 0, -1, 1, 0, 1);
        cyc(1, 0, 0, 0, 1, 1);
        cyc(1, 0, 0, 0, 0, 1);
        // R10: clamping off leaves the large value and no flag
        req_a = "R10"; req_s = "R10";
        cyc(1, 0, 0, 0, 1, 0);
        cyc(1, 0, 0, 0, 0, 0);
        flush();

        // R2: wrap of the 44-bit accumulator
        req_a = "R2"; req_s = "R2";
        cyc(1, 1, -131072, -131072, 0, 0);
        for (int k = 0; k < 600; k++) cyc(1, 0, -131072, -131072, k[0], 0);
        flush();

        // Random mix
        req_a = "RANDOM R4"; req_s = "RANDOM R8";
        for (int k = 0; k < 500; k++) begin
            longint ra, rb;
            bit rv, rc;
            ra = longint'($signed(AW'($urandom)));
            rb = longint'($signed(BW'($urandom)));
            if (($urandom % 4) == 0) ra = (($urandom % 2) == 0) ? -131072 : 131071;
            if (($urandom % 4) == 0) rb = (($urandom % 2) == 0) ? -131072 : 131071;
            rv = (($urandom % 8) != 0);
            rc = (($urandom % 24) == 0);
            cyc(rv, rc, ra, rb, bit'($urandom % 2), bit'($urandom % 2));
        end
        flush();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule